// File: doc/BRIEF.md
# Pipelined Three-Operand Adder

This block is a five-stage pipeline (fetch, decode, first execute, second execute, write-back) that runs a single kind of instruction: a destination register receives the sum of three source registers. An instruction whose run bit is clear is a NOP. Programs are placed in a small instruction memory through a write port while reset is held. After reset is released the pipeline fetches one word per cycle from address 0. The only visible result is the write-back trio: enable, register address and data.

The first execute stage adds X and Y. The second execute stage adds Z to that partial sum. Because Z is consumed one stage later, a Z dependency never stalls. It is caught either by a mux in the first execute stage or by a later mux in the second. An X or Y dependency on the instruction directly ahead costs one bubble, and later dependencies are forwarded. A carry out of either adder marks unsigned overflow. The instruction then becomes a NOP: it neither writes a register nor feeds a later instruction.

Top module: `tri_add_pipe`

## Requirements
- R1: Instruction word layout: bit 16 = run, [15:12] = destination R, [11:8] = Z, [7:4] = Y, [3:0] = X. While `rst` is high `wb_we` is 0. After reset, register i holds the value i.
- R2: A running instruction writes X+Y+Z into register R. Writes appear in program order. The write of the first instruction is visible after the fourth rising edge following reset release, and each later instruction writes one cycle after its predecessor unless a bubble intervenes.
- R3: An instruction with run = 0 writes nothing and changes no register, whatever its other fields hold. It never causes a stall.
- R4: If X+Y carries out of DATA_W bits, or (X+Y)+Z carries out, the instruction writes nothing. A later instruction that depends on it sees the register's previous value.
- R5: When X or Y of an instruction names the destination of the running instruction directly ahead, one bubble is inserted. PC and the fetched word hold for that cycle, and the result is still correct.
- R6: An X or Y dependency on the instruction two ahead is satisfied by forwarding, with no bubble.
- R7: A Z dependency on the instruction one or two ahead is satisfied by forwarding, with no bubble.
- R8: A source read in decode in the same cycle that its register is written receives the new value.
- R9: When several instructions ahead target the same register, the youngest of them supplies the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| im_we | input | 1 | Instruction memory write enable |
| im_addr | input | IMEM_AW | Instruction memory write address |
| im_wdata | input | INS_W | Instruction word to store |
| wb_we | output | 1 | Register write enable from write-back |
| wb_addr | output | REG_AW | Register written |
| wb_data | output | DATA_W | Value written |

## Verification
A stall and a forward from write-back can fall in the same cycle. This happens when an instruction depends through X on the instruction directly ahead and through Z on the one before that, and the bench provokes it with same-register chains. Overflow kill and forwarding can also coincide when a killed instruction is immediately followed by a dependent one. The scoreboard judges every case by the value and by the exact cycle of each write, so a missing bubble, an extra bubble or a forward from a killed source all show up.

// File: rtl/tap_pkg.sv
package tap_pkg;
  // forwarding selections decided in decode, consumed downstream
  typedef struct packed {
    logic x_wb;   // X takes write-back result in EX1
    logic y_wb;   // Y takes write-back result in EX1
    logic z_wb1;  // Z takes write-back result in EX1
    logic z_wb2;  // Z takes write-back result in EX2
  } fwd_t;
endpackage

// File: rtl/tap_imem.sv
module tap_imem #(
  parameter int AW = 5,
  parameter int DW = 17,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read doubles as the fetch/decode pipeline register
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tap_regfile.sv
module tap_regfile #(
  parameter int AW  = 4,
  parameter int DW  = 8,
  parameter int NRD = 3,
  localparam int DEPTH = 1 << AW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);
  logic [DW-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= DW'(i);
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  // same-cycle write is bypassed to every read port
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (we && waddr == raddr[g]) ? wdata : regs[raddr[g]];
  end

  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/tap_hazard.sv
module tap_hazard
  import tap_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          id_run,
  input  logic [AW-1:0] id_x,
  input  logic [AW-1:0] id_y,
  input  logic [AW-1:0] id_z,
  input  logic          ex1_run,
  input  logic [AW-1:0] ex1_r,
  input  logic          ex2_run,
  input  logic [AW-1:0] ex2_r,
  output logic          stall,
  output fwd_t          fwd
);
  logic x_on_ex1, y_on_ex1, z_on_ex1;
  logic x_on_ex2, y_on_ex2, z_on_ex2;

  always_comb begin
    x_on_ex1 = ex1_run && (ex1_r == id_x);
    y_on_ex1 = ex1_run && (ex1_r == id_y);
    z_on_ex1 = ex1_run && (ex1_r == id_z);
    x_on_ex2 = ex2_run && (ex2_r == id_x);
    y_on_ex2 = ex2_run && (ex2_r == id_y);
    z_on_ex2 = ex2_run && (ex2_r == id_z);
    stall     = id_run && (x_on_ex1 || y_on_ex1);
    fwd.x_wb  = x_on_ex2;
    fwd.y_wb  = y_on_ex2;
    fwd.z_wb1 = z_on_ex2;   // older senior, caught at EX1
    fwd.z_wb2 = z_on_ex1;   // younger senior, overrides at EX2
  end
endmodule

// File: rtl/tri_add_pipe.sv
module tri_add_pipe
  import tap_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int REG_AW  = 4,
  parameter int IMEM_AW = 5,
  localparam int INS_W  = 1 + 4 * REG_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               im_we,
  input  logic [IMEM_AW-1:0] im_addr,
  input  logic [INS_W-1:0]   im_wdata,
  output logic               wb_we,
  output logic [REG_AW-1:0]  wb_addr,
  output logic [DATA_W-1:0]  wb_data
);
  localparam int X_LSB   = 0;
  localparam int Y_LSB   = REG_AW;
  localparam int Z_LSB   = 2 * REG_AW;
  localparam int R_LSB   = 3 * REG_AW;
  localparam int RUN_BIT = 4 * REG_AW;

  logic [IMEM_AW-1:0] pc;
  logic [INS_W-1:0]   ifid;
  logic               stall;
  fwd_t               id_fwd;

  // ---------------- fetch ----------------
  always_ff @(posedge clk) begin
    if (rst)         pc <= '0;
    else if (!stall) pc <= pc + 1'b1;
  end

  tap_imem #(.AW(IMEM_AW), .DW(INS_W)) u_imem (
    .clk(clk), .rst(rst), .we(im_we), .waddr(im_addr), .wdata(im_wdata),
    .re(!stall), .raddr(pc), .rdata(ifid)
  );

  // ---------------- decode ----------------
  logic              id_run;
  logic [REG_AW-1:0] id_x, id_y, id_z, id_r;
  logic [2:0][REG_AW-1:0] rf_ra;
  logic [2:0][DATA_W-1:0] rf_rd;

  assign id_run = ifid[RUN_BIT];
  assign id_x   = ifid[X_LSB +: REG_AW];
  assign id_y   = ifid[Y_LSB +: REG_AW];
  assign id_z   = ifid[Z_LSB +: REG_AW];
  assign id_r   = ifid[R_LSB +: REG_AW];
  assign rf_ra  = {id_z, id_y, id_x};

  tap_regfile #(.AW(REG_AW), .DW(DATA_W), .NRD(3)) u_rf (
    .clk(clk), .rst(rst), .we(wb_we), .waddr(wb_addr), .wdata(wb_data),
    .raddr(rf_ra), .rdata(rf_rd)
  );

  logic              e1_run;
  logic [REG_AW-1:0] e1_r;
  logic [DATA_W-1:0] e1_xd, e1_yd, e1_zd;
  fwd_t              e1_fwd;
  logic              e2_run;
  logic [REG_AW-1:0] e2_r;
  logic [DATA_W-1:0] e2_p, e2_z;
  logic              e2_zf;

  tap_hazard #(.AW(REG_AW)) u_hz (
    .id_run(id_run), .id_x(id_x), .id_y(id_y), .id_z(id_z),
    .ex1_run(e1_run), .ex1_r(e1_r), .ex2_run(e2_run), .ex2_r(e2_r),
    .stall(stall), .fwd(id_fwd)
  );

  always_ff @(posedge clk) begin
    if (rst) e1_run <= 1'b0;
    else     e1_run <= id_run && !stall;   // bubble on stall
  end
  always_ff @(posedge clk) begin
    e1_r   <= id_r;
    e1_xd  <= rf_rd[0];
    e1_yd  <= rf_rd[1];
    e1_zd  <= rf_rd[2];
    e1_fwd <= id_fwd;
  end

  // ---------------- EX1: X + Y ----------------
  logic [DATA_W-1:0] x_op, y_op, z_op1;
  logic [DATA_W:0]   sum1;

  always_comb begin
    x_op  = (e1_fwd.x_wb  && wb_we) ? wb_data : e1_xd;
    y_op  = (e1_fwd.y_wb  && wb_we) ? wb_data : e1_yd;
    z_op1 = (e1_fwd.z_wb1 && wb_we) ? wb_data : e1_zd;
    sum1  = {1'b0, x_op} + {1'b0, y_op};
  end

  always_ff @(posedge clk) begin
    if (rst) e2_run <= 1'b0;
    else     e2_run <= e1_run && !sum1[DATA_W];
  end
  always_ff @(posedge clk) begin
    e2_r  <= e1_r;
    e2_p  <= sum1[DATA_W-1:0];
    e2_z  <= z_op1;
    e2_zf <= e1_fwd.z_wb2;
  end

  // ---------------- EX2: partial + Z ----------------
  logic [DATA_W-1:0] z_op2;
  logic [DATA_W:0]   sum2;

  always_comb begin
    z_op2 = (e2_zf && wb_we) ? wb_data : e2_z;
    sum2  = {1'b0, e2_p} + {1'b0, z_op2};
  end

  // ---------------- WB ----------------
  always_ff @(posedge clk) begin
    if (rst) wb_we <= 1'b0;
    else     wb_we <= e2_run && !sum2[DATA_W];
  end
  always_ff @(posedge clk) begin
    wb_addr <= e2_r;
    wb_data <= sum2[DATA_W-1:0];
  end

  // ---------------- assertions ----------------
  p_stall_holds_pc_r5: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc));
  p_stall_bubble_r5: assert property (@(posedge clk) disable iff (rst)
    stall |=> !e1_run);
  p_single_stall_r5: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);
  p_no_overflow_ex1_r4: assert property (@(posedge clk) disable iff (rst)
    (e1_run && sum1[DATA_W]) |=> !e2_run);
  p_no_overflow_ex2_r4: assert property (@(posedge clk) disable iff (rst)
    (e2_run && sum2[DATA_W]) |=> !wb_we);
  p_nop_silent_r3: assert property (@(posedge clk) disable iff (rst)
    !e2_run |=> !wb_we);
endmodule

// File: tb/tri_add_pipe_bench.sv
`timescale 1ns/1ps
module tri_add_pipe_bench;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int IAW = 5;
  localparam int IW = 1 + 4 * AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic im_we = 1'b0;
  logic [IAW-1:0] im_addr = '0;
  logic [IW-1:0]  im_wdata = '0;
  logic           wb_we;
  logic [AW-1:0]  wb_addr;
  logic [DW-1:0]  wb_data;

  always #10 clk = ~clk;   // 50 MHz

  tri_add_pipe #(.DATA_W(DW), .REG_AW(AW), .IMEM_AW(IAW)) u_tri_add_pipe (
    .clk(clk), .rst(rst), .im_we(im_we), .im_addr(im_addr), .im_wdata(im_wdata),
    .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string cur_tag = "";

  // scoreboard queues: cycle, address, data
  int qc[$];
  int qa[$];
  int qd[$];

  logic [IW-1:0] prog [32];
  int plen = 0;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // monitor
  int mc, ma, md;
  always @(negedge clk) begin
    if (!rst && wb_we) begin
      checks++;
      if (qc.size() == 0) begin
        failures++;
        $display("FAIL %s unexpected write: r%0d=%0d at cycle %0d (expected none)",
                 cur_tag, wb_addr, wb_data, cyc);
      end else begin
        mc = qc.pop_front();
        ma = qa.pop_front();
        md = qd.pop_front();
        if (mc != cyc || ma != int'(wb_addr) || md != int'(wb_data)) begin
          failures++;
          $display("FAIL %s write: got r%0d=%0d at cycle %0d, expected r%0d=%0d at cycle %0d",
                   cur_tag, wb_addr, wb_data, cyc, ma, md, mc);
        end
      end
    end
  end

  task automatic clear_prog();
    plen = 0;
  endtask

  task automatic add_i(input int r, input int z, input int y, input int x);
    prog[plen] = {1'b1, AW'(r), AW'(z), AW'(y), AW'(x)};
    plen++;
  endtask

  task automatic nop_i(input int r, input int z, input int y, input int x);
    prog[plen] = {1'b0, AW'(r), AW'(z), AW'(y), AW'(x)};
    plen++;
  endtask

  // reference model: sequential semantics plus issue timing
  task automatic build_expect();
    int m [16];
    int e, s, r, z, y, x;
    bit run, prev_run, stl;
    int prev_r;
    for (int i = 0; i < 16; i++) m[i] = i;  // R1 reset contents
    e = 1;
    prev_run = 0;
    prev_r = 0;
    for (int k = 0; k < plen; k++) begin
      run = prog[k][16];
      r = int'(prog[k][15:12]);
      z = int'(prog[k][11:8]);
      y = int'(prog[k][7:4]);
      x = int'(prog[k][3:0]);
      stl = run && prev_run && (x == prev_r || y == prev_r);   // R5
      e = e + 1 + int'(stl);
      if (run) begin
        s = m[x] + m[y] + m[z];
        if (s < (1 << DW)) begin    // R4: overflow writes nothing
          qc.push_back(e + 2);
          qa.push_back(r);
          qd.push_back(s);
          m[r] = s;
        end
      end
      prev_run = run;
      prev_r = r;
    end
  endtask

  task automatic run_prog(input string tag);
    cur_tag = tag;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      im_we = 1'b1;
      im_addr = IAW'(i);
      im_wdata = (i < plen) ? prog[i] : '0;
      @(negedge clk);
    end
    im_we = 1'b0;
    checks++;   // R1: no write during reset
    if (wb_we !== 1'b0) begin
      failures++;
      $display("FAIL R1 wb_we during reset: got %b expected 0", wb_we);
    end
    build_expect();
    rst = 1'b0;
    repeat (30) @(negedge clk);
    checks++;   // R2: all expected writes happened
    if (qc.size() != 0) begin
      failures++;
      $display("FAIL %s missing writes: got %0d pending expected 0", tag, qc.size());
      qc.delete(); qa.delete(); qd.delete();
    end
    rst = 1'b1;
  endtask

  initial begin
    // R1 R2: independent adds from reset contents, with a NOP gap
    clear_prog();
    add_i(5, 3, 2, 1);
    add_i(7, 10, 9, 8);
    nop_i(0, 0, 0, 0);
    add_i(0, 13, 14, 15);
    add_i(6, 6, 6, 6);
    run_prog("R1 R2");

    // R5: X then Y depend on the instruction directly ahead
    clear_prog();
    add_i(1, 4, 3, 2);
    add_i(5, 7, 6, 1);
    add_i(8, 0, 5, 2);
    add_i(9, 9, 9, 9);
    run_prog("R5");

    // R6 R7 R8: two-ahead X, immediate and two-ahead Z, three-ahead read
    clear_prog();
    add_i(1, 3, 2, 1);
    add_i(2, 1, 5, 4);
    add_i(3, 7, 6, 1);
    add_i(4, 2, 9, 8);
    add_i(5, 0, 2, 3);
    run_prog("R6 R7 R8");

    // R9: youngest senior wins, with a stall and without
    clear_prog();
    add_i(1, 4, 3, 2);
    add_i(1, 7, 6, 5);
    add_i(9, 1, 0, 1);
    add_i(1, 13, 12, 11);
    add_i(1, 0, 15, 14);
    add_i(10, 1, 3, 2);
    run_prog("R9");

    // R4: overflow in EX1 and in EX2, dependents see old values
    clear_prog();
    add_i(1, 13, 14, 15);
    add_i(2, 1, 1, 1);
    add_i(3, 0, 2, 2);
    add_i(4, 0, 2, 3);
    add_i(5, 0, 0, 4);
    add_i(6, 3, 0, 2);
    add_i(7, 6, 0, 0);
    run_prog("R4");

    // R3: NOPs with live-looking fields write nothing and cause no stall
    clear_prog();
    add_i(1, 0, 0, 15);
    nop_i(1, 2, 2, 2);
    nop_i(2, 1, 1, 1);
    add_i(8, 1, 1, 1);
    nop_i(8, 8, 8, 8);
    add_i(9, 2, 8, 8);
    run_prog("R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    failures++;
    $display("FAIL watchdog expired: got running expected done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule